// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address for a processor with a one-megabyte address space. It holds four segment registers (code, data, stack, extra) and an instruction pointer. Each request carries an access kind, and the block uses that kind to pick the segment register that supplies the base. The physical address is the segment value times sixteen plus the offset, kept to 20 bits.

An optional segment override (an enable plus a 2-bit selector) redirects some access kinds to a different segment register. Instruction fetches take their offset from the internal instruction pointer, and the request offset is not used for them. The instruction pointer advances by an instruction length or jumps to a target. It can only be changed through those two controls. The result and its valid strobe appear one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is active, and at the first sample after it is released, `addr_valid` is 0, `phys_addr` is 0 and `ip_value` is 0. All four segment registers clear to 0, so any request made before a segment write produces address 0.
- R2: For a request with segment value S and offset O, `phys_addr` equals (S*16 + O) mod 2^20.
- R3: When the sum overflows 20 bits, the carry is dropped. For example, FFFF:0010 gives 00000h and FFFF:FFFF gives 0FFEFh.
- R4: When `seg_wr_en` is 1, `seg_wr_data` is written to the register named by `seg_wr_sel` (0 code, 1 data, 2 stack, 3 extra). A request in the same cycle still uses the register's previous value.
- R5: Kind 0 (fetch) uses the code segment with `ip_value` as offset. `req_offset` and the override are ignored. A fetch in the same cycle as a pointer update uses the pointer's old value.
- R6: Kind 1 (stack) uses the stack segment with `req_offset`, and the override is ignored.
- R7: Kind 2 (base-pointer) uses the stack segment by default. When `ovr_en` is 1 it uses the register selected by `ovr_sel`, with the same encoding as R4.
- R8: Kind 3 (data source), and kinds 5 to 7, use the data segment by default. When `ovr_en` is 1 they use the register selected by `ovr_sel`.
- R9: Kind 4 (string destination) always uses the extra segment, and the override is ignored.
- R10: `ip_jmp_en` loads `ip_jmp_val` and takes priority over `ip_inc_en`. Otherwise `ip_inc_en` adds `ip_inc_len` modulo 2^16. With neither control asserted, the pointer holds its value.
- R11: `addr_valid` is 1 in exactly the cycle after each request. With no request, `addr_valid` is 0 and `phys_addr` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | 16 | New segment value |
| ip_inc_en | input | 1 | Advance the instruction pointer |
| ip_inc_len | input | 4 | Advance amount in bytes |
| ip_jmp_en | input | 1 | Load the instruction pointer |
| ip_jmp_val | input | 16 | Jump target offset |
| req_valid | input | 1 | Address request |
| req_kind | input | 3 | Access kind |
| req_offset | input | 16 | Offset for non-fetch kinds |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment choice |
| addr_valid | output | 1 | Address result strobe |
| phys_addr | output | 20 | Physical address |
| ip_value | output | 16 | Current instruction pointer |

## Verification
A wrong segment register or a wrong default choice shows up as a wrong `phys_addr` one cycle after the request. Every access kind is therefore paired with distinct segment contents, so that any wrong choice of register produces a different address. A corrupted instruction pointer shows on `ip_value` at the next sample and on the next fetch address. A broken pipeline strobe shows as a missing or extra `addr_valid` in the cycle after a request.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
   typedef enum logic [1:0] {
      SEG_CODE  = 2'd0,
      SEG_DATA  = 2'd1,
      SEG_STACK = 2'd2,
      SEG_EXTRA = 2'd3
   } seg_id_e;

   typedef enum logic [2:0] {
      ACC_FETCH = 3'd0,
      ACC_STACK = 3'd1,
      ACC_BASE  = 3'd2,
      ACC_DATA  = 3'd3,
      ACC_DEST  = 3'd4
   } acc_kind_e;

   localparam int NUM_SEGS = 4;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
   parameter int SEG_W = 16,
   parameter int NSEG  = 4,
   localparam int SEL_W = $clog2(NSEG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [SEG_W-1:0] wr_data,
   output logic [SEG_W-1:0] seg_q [NSEG]
);
   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            seg_q[i] <= '0;
         else if (wr_en && (wr_sel == SEL_W'(i)))
            seg_q[i] <= wr_data;
      end
   end
endmodule

// File: rtl/ip_counter.sv
module ip_counter #(
   parameter int OFF_W = 16,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_en,
   input  logic [LEN_W-1:0] inc_len,
   input  logic             jmp_en,
   input  logic [OFF_W-1:0] jmp_val,
   output logic [OFF_W-1:0] ip_q
);
   logic [OFF_W-1:0] step;
   assign step = {{(OFF_W-LEN_W){1'b0}}, inc_len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ip_q <= '0;
      else if (jmp_en)
         ip_q <= jmp_val;
      else if (inc_en)
         ip_q <= ip_q + step;
   end
endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_addr_pkg::*;
(
   input  logic [2:0] kind,
   input  logic       ovr_en,
   input  logic [1:0] ovr_sel,
   output logic [1:0] sel
);
   always_comb begin
      case (kind)
         ACC_FETCH: sel = SEG_CODE;
         ACC_STACK: sel = SEG_STACK;
         ACC_BASE:  sel = ovr_en ? ovr_sel : SEG_STACK;
         ACC_DEST:  sel = SEG_EXTRA;
         default:   sel = ovr_en ? ovr_sel : SEG_DATA;
      endcase
   end
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SHIFT     = 4,
   parameter bit SPLIT_ADD = 1'b1,
   localparam int PA_W     = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  pa
);
   if (SPLIT_ADD) begin : g_split
      logic [SEG_W-1:0] hi;
      assign hi = seg + SEG_W'(off >> SHIFT);
      assign pa = {hi, off[SHIFT-1:0]};
   end else begin : g_full
      assign pa = {seg, {SHIFT{1'b0}}} + PA_W'(off);
   end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SHIFT     = 4,
   parameter int LEN_W     = 4,
   parameter bit SPLIT_ADD = 1'b1,
   localparam int PA_W     = SEG_W + SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seg_wr_en,
   input  logic [1:0]       seg_wr_sel,
   input  logic [SEG_W-1:0] seg_wr_data,
   input  logic             ip_inc_en,
   input  logic [LEN_W-1:0] ip_inc_len,
   input  logic             ip_jmp_en,
   input  logic [OFF_W-1:0] ip_jmp_val,
   input  logic             req_valid,
   input  logic [2:0]       req_kind,
   input  logic [OFF_W-1:0] req_offset,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_sel,
   output logic             addr_valid,
   output logic [PA_W-1:0]  phys_addr,
   output logic [OFF_W-1:0] ip_value
);
   if (OFF_W <= SHIFT) begin : g_bad_off
      $error("seg_addr_gen: OFF_W must exceed SHIFT");
   end
   if (OFF_W > PA_W) begin : g_bad_pa
      $error("seg_addr_gen: OFF_W must not exceed the address width");
   end
   if (LEN_W >= OFF_W) begin : g_bad_len
      $error("seg_addr_gen: LEN_W must be narrower than OFF_W");
   end

   logic [SEG_W-1:0] seg_q [NUM_SEGS];
   logic [1:0]       sel;
   logic [OFF_W-1:0] eff_off;
   logic [PA_W-1:0]  pa_next;

   seg_regfile #(.SEG_W(SEG_W), .NSEG(NUM_SEGS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (seg_wr_en),
      .wr_sel  (seg_wr_sel),
      .wr_data (seg_wr_data),
      .seg_q   (seg_q)
   );

   ip_counter #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_ip (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (ip_inc_en),
      .inc_len (ip_inc_len),
      .jmp_en  (ip_jmp_en),
      .jmp_val (ip_jmp_val),
      .ip_q    (ip_value)
   );

   seg_select u_sel (
      .kind    (req_kind),
      .ovr_en  (ovr_en),
      .ovr_sel (ovr_sel),
      .sel     (sel)
   );

   assign eff_off = (req_kind == ACC_FETCH) ? ip_value : req_offset;

   addr_adder #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .SPLIT_ADD(SPLIT_ADD)
   ) u_add (
      .seg (seg_q[sel]),
      .off (eff_off),
      .pa  (pa_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_valid <= 1'b0;
         phys_addr  <= '0;
      end else begin
         addr_valid <= req_valid;
         if (req_valid)
            phys_addr <= pa_next;
      end
   end
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   parameter int LEN_W = 4,
   localparam int PA_W = SEG_W + SHIFT
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ip_inc_en,
   input logic [LEN_W-1:0] ip_inc_len,
   input logic             ip_jmp_en,
   input logic [OFF_W-1:0] ip_jmp_val,
   input logic             req_valid,
   input logic [2:0]       req_kind,
   input logic [OFF_W-1:0] req_offset,
   input logic             addr_valid,
   input logic [PA_W-1:0]  phys_addr,
   input logic [OFF_W-1:0] ip_value
);
   p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> addr_valid);

   p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !addr_valid);

   p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(phys_addr));

   p_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != 3'd0) |=>
         phys_addr[SHIFT-1:0] == $past(req_offset[SHIFT-1:0]));

   p_fetch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 3'd0) |=>
         phys_addr[SHIFT-1:0] == $past(ip_value[SHIFT-1:0]));

   p_ip_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ip_jmp_en |=> ip_value == $past(ip_jmp_val));

   p_ip_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ip_inc_en && !ip_jmp_en) |=>
         ip_value == $past(ip_value) + OFF_W'($past(ip_inc_len)));

   p_ip_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ip_inc_en && !ip_jmp_en) |=> $stable(ip_value));
endmodule

bind seg_addr_gen seg_addr_chk #(
   .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        seg_wr_en;
   logic [1:0]  seg_wr_sel;
   logic [15:0] seg_wr_data;
   logic        ip_inc_en;
   logic [3:0]  ip_inc_len;
   logic        ip_jmp_en;
   logic [15:0] ip_jmp_val;
   logic        req_valid;
   logic [2:0]  req_kind;
   logic [15:0] req_offset;
   logic        ovr_en;
   logic [1:0]  ovr_sel;
   logic        addr_valid;
   logic [19:0] phys_addr;
   logic [15:0] ip_value;

   always #5 clk = ~clk;

   seg_addr_gen u0 (
      .clk(clk), .rst_n(rst_n),
      .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
      .ip_inc_en(ip_inc_en), .ip_inc_len(ip_inc_len),
      .ip_jmp_en(ip_jmp_en), .ip_jmp_val(ip_jmp_val),
      .req_valid(req_valid), .req_kind(req_kind), .req_offset(req_offset),
      .ovr_en(ovr_en), .ovr_sel(ovr_sel),
      .addr_valid(addr_valid), .phys_addr(phys_addr), .ip_value(ip_value)
   );

   // Bench model, written from the requirements
   logic [15:0] m_seg [4];
   logic [15:0] m_ip;
   logic [19:0] last_exp;
   logic [19:0] q_addr [$];
   string       q_tag [$];
   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
      int sum;
      sum = (int'(s) * 16) + int'(o);
      return 20'(sum % 1048576);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit we, input logic [1:0] ws, input logic [15:0] wd,
                      input bit rq, input logic [2:0] k, input logic [15:0] off,
                      input bit oe, input logic [1:0] os,
                      input bit ie, input logic [3:0] il,
                      input bit je, input logic [15:0] jv, input string tag);
      int si;
      logic [15:0] o;
      @(posedge clk); #1;
      seg_wr_en = we; seg_wr_sel = ws; seg_wr_data = wd;
      req_valid = rq; req_kind = k; req_offset = off;
      ovr_en = oe; ovr_sel = os;
      ip_inc_en = ie; ip_inc_len = il; ip_jmp_en = je; ip_jmp_val = jv;
      if (rq) begin
         case (k)
            3'd0: si = 0;
            3'd1: si = 2;
            3'd2: si = oe ? int'(os) : 2;
            3'd4: si = 3;
            default: si = oe ? int'(os) : 1;
         endcase
         o = (k == 3'd0) ? m_ip : off;
         last_exp = phys(m_seg[si], o);
         q_addr.push_back(last_exp);
         q_tag.push_back(tag);
      end
      if (we) m_seg[ws] = wd;
      if (je) m_ip = jv;
      else if (ie) m_ip = m_ip + 16'(il);
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   task automatic wseg(input logic [1:0] s, input logic [15:0] v);
      cyc(1, s, v, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   task automatic req(input logic [2:0] k, input logic [15:0] off,
                      input bit oe, input logic [1:0] os, input string tag);
      cyc(0, 0, 0, 1, k, off, oe, os, 0, 0, 0, 0, tag);
   endtask

   task automatic chk_ip(input string tag);
      idle();
      @(negedge clk);
      chk(tag, 32'(ip_value), 32'(m_ip));
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Monitor: pops the scoreboard whenever a result appears
   always @(negedge clk) begin
      if (rst_n === 1'b1 && addr_valid === 1'b1) begin
         if (q_addr.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 actual=valid expected=no result");
         end else begin
            logic [19:0] e;
            string t;
            e = q_addr.pop_front();
            t = q_tag.pop_front();
            chk(t, 32'(phys_addr), 32'(e));
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) m_seg[i] = '0;
      m_ip = '0;
      last_exp = '0;
      rst_n = 1'b0;
      seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
      ip_inc_en = 0; ip_inc_len = 0; ip_jmp_en = 0; ip_jmp_val = 0;
      req_valid = 0; req_kind = 0; req_offset = 0; ovr_en = 0; ovr_sel = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 valid in reset", 32'(addr_valid), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid", 32'(addr_valid), 0);
      chk("R1 addr", 32'(phys_addr), 0);
      chk("R1 ip", 32'(ip_value), 0);
      // R1: cleared segments give address 0 for every kind
      req(3'd3, 16'h0000, 0, 0, "R1 data");
      req(3'd1, 16'h0000, 0, 0, "R1 stack");
      req(3'd4, 16'h0000, 0, 0, "R1 dest");
      req(3'd0, 16'h0000, 0, 0, "R1 fetch");
      // R2 / R8: data segment default
      wseg(2'd1, 16'hA4FB);
      req(3'd3, 16'h4872, 0, 0, "R2 A4FB:4872");
      // R6: stack kind, override ignored
      wseg(2'd2, 16'h7500);
      req(3'd1, 16'hBFD2, 0, 0, "R6 stack");
      req(3'd1, 16'hBFD2, 1, 2'd1, "R6 override ignored");
      // R9: destination always extra
      wseg(2'd3, 16'h1256);
      req(3'd4, 16'h000A, 1, 2'd2, "R9 dest override ignored");
      // R7: base kind default and overridden
      wseg(2'd1, 16'h1240);
      req(3'd2, 16'h016A, 1, 2'd1, "R7 base override data");
      req(3'd2, 16'h0010, 0, 0, "R7 base default stack");
      // R8: data kind overrides, and an unused kind code
      req(3'd3, 16'h0005, 1, 2'd3, "R8 data override extra");
      req(3'd3, 16'h0007, 1, 2'd0, "R8 data override code");
      req(3'd6, 16'h0020, 0, 0, "R8 kind 6 as data");
      // R3: carry out of bit 19 dropped
      wseg(2'd1, 16'hFFFF);
      req(3'd3, 16'h0010, 0, 0, "R3 wrap to zero");
      req(3'd3, 16'hFFFF, 0, 0, "R3 wrap max");
      // R4: write and request in the same cycle use the old value
      cyc(1, 2'd1, 16'h2000, 1, 3'd3, 16'h0003, 0, 0, 0, 0, 0, 0, "R4 old value");
      req(3'd3, 16'h0003, 0, 0, "R4 new value");
      // R5: fetch uses code segment and pointer
      wseg(2'd0, 16'h0F8A);
      req(3'd0, 16'h1234, 1, 2'd3, "R5 fetch ignores offset");
      // R10: pointer step, jump, wrap, priority
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd3, 0, 0, "");
      chk_ip("R10 step");
      req(3'd0, 16'h0000, 0, 0, "R5 fetch after step");
      cyc(0, 0, 0, 1, 3'd0, 0, 0, 0, 1, 4'd5, 0, 0, "R5 fetch uses old pointer");
      chk_ip("R10 step 5");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFFE, "");
      chk_ip("R10 jump");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd4, 0, 0, "");
      chk_ip("R10 wrap");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd7, 1, 16'h0100, "");
      chk_ip("R10 jump priority");
      idle();
      chk_ip("R10 hold");
      // R11: results hold and strobe drops with no request
      req(3'd2, 16'h0044, 0, 0, "R11 back to back a");
      req(3'd4, 16'h0045, 0, 0, "R11 back to back b");
      idle();
      idle();
      @(negedge clk);
      chk("R11 idle valid", 32'(addr_valid), 0);
      chk("R11 idle hold", 32'(phys_addr), 32'(last_exp));
      repeat (3) idle();
      @(negedge clk);
      chk("R11 all results seen", 32'(q_addr.size()), 0);
      done = 1'b1;
      summary();
   end
endmodule